// File: doc/BRIEF.md
# Multi-Word Two's Complement Arithmetic Sequencer

This block performs arithmetic on signed integers of one to sixteen 16-bit words, in two's complement form. Operands live in two 16-word register files, the S pad and the T pad. An operand of n words fills indices n-1 down to 0, with index 0 the least significant word and the sign in bit 15 of word n-1. Unary operations rewrite the S operand in place. Binary operations combine the S operand with the T operand and leave the result in S.

All computation passes through two working registers, A and B. Every word takes three clock cycles. In the first, the word at the current index is copied from S into A and the partner word is copied into B. In the second, A is replaced by the result and a one-bit carry register is updated. In the third, A is written back into S. The carry register carries the carry, borrow, increment or shifted-out bit from one word to the next.

The host fills the pads through a write port while the block is idle. It selects an operation and a word count and pulses `start`, then waits for the single-cycle `done` strobe and reads the results through a registered read port. A mapping mode can make the T operand come from S at a fixed index offset, so that both operands sit in one pad.

Top module: `mwa_top`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `busy` and `done` are low.
- R2: Opcode 0 (add) replaces words 0..n-1 of S with the low 16n bits of S + T. The carry passes upward from word 0. Words at index n and above are left unchanged.
- R3: Opcode 1 (subtract) replaces words 0..n-1 of S with the low 16n bits of S - T. The borrow passes upward from word 0.
- R4: Opcode 2 (negate) replaces words 0..n-1 of S with the low 16n bits of 0 - S. The most negative value maps to itself.
- R5: Opcode 3 (increment) replaces words 0..n-1 of S with the low 16n bits of S + 1. All ones wraps to zero.
- R6: Opcode 4 (shift left) moves the n-word S value left by one bit. Bit 15 of each word enters bit 0 of the next higher word, zero enters bit 0 of word 0, and bit 15 of word n-1 is lost.
- R7: Opcode 5 (arithmetic shift right) moves the n-word S value right by one bit. The sign bit of word n-1 is kept, and bit 0 of each word enters bit 15 of the next lower word.
- R8: When `start` is accepted at a clock edge, `done` is high for exactly one cycle, 3n clock edges later. `busy` is high from the edge after acceptance until `done` is raised.
- R9: A `start` pulse that arrives while `busy` is high has no effect. It neither alters the result nor delays `done`.
- R10: A `start` with opcode 6 or 7 is ignored. `busy` and `done` stay low and S is unchanged.
- R11: With `t_map` high, the second operand word i is taken from S at index (i + `t_base`) mod 16 rather than from T at index i.
- R12: `count` holds n-1. A count of 0 operates on S[0] alone.
- R13: Host writes to S or T that are requested while `busy` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Requests an operation; sampled only when idle |
| opcode | input | 3 | 0 add, 1 sub, 2 negate, 3 increment, 4 shift left, 5 arithmetic shift right |
| count | input | 4 | Number of words minus one |
| t_map | input | 1 | Take the second operand from S at an offset; hold steady while busy |
| t_base | input | 4 | Index offset used when `t_map` is high; hold steady while busy |
| s_we | input | 1 | Host write enable for S |
| t_we | input | 1 | Host write enable for T |
| wr_addr | input | 4 | Host write index |
| wr_data | input | 16 | Host write data |
| rd_sel | input | 1 | Host read source: 0 S, 1 T |
| rd_addr | input | 4 | Host read index |
| rd_data | output | 16 | Registered read data, valid one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest cases to reach from the ports are those where the carry register has to pass a bit across several word boundaries, and those where a host action lands in the middle of a running operation. Operands of all-ones words force carries and borrows through every word of 3- and 4-word operations. Shift patterns put a set bit at each word edge. Directed tasks drive a second `start` and host writes to both pads a few cycles after an accepted start, while `busy` is high. A read-back of all 16 S words and the affected T word then shows that none of these actions took effect.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_NEG = 3'd2,
    OP_INC = 3'd3,
    OP_SHL = 3'd4,
    OP_SAR = 3'd5
  } op_e;

  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  // carry register value loaded before the first word
  function automatic logic op_cin0(input logic [2:0] code);
    return (code == OP_SUB) || (code == OP_NEG) || (code == OP_INC);
  endfunction
endpackage

// File: rtl/mwa_spad.sv
module mwa_spad #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*W +: W] = mem[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/mwa_alu.sv
module mwa_alu
  import mwa_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         first,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W:0] sum;
  logic       fill;

  always_comb begin
    sum  = '0;
    fill = first ? a[W-1] : cin;
    res  = a;
    cout = 1'b0;
    case (op)
      OP_ADD: begin
        sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        {cout, res} = sum;
      end
      OP_SUB: begin
        sum = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
        {cout, res} = sum;
      end
      OP_NEG: begin
        sum = {1'b0, ~a} + {{W{1'b0}}, cin};
        {cout, res} = sum;
      end
      OP_INC: begin
        sum = {1'b0, a} + {{W{1'b0}}, cin};
        {cout, res} = sum;
      end
      OP_SHL: begin
        res  = {a[W-2:0], cin};
        cout = a[W-1];
      end
      OP_SAR: begin
        res  = {fill, a[W-1:1]};
        cout = a[0];
      end
      default: begin
        res  = a;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/mwa_ctrl.sv
module mwa_ctrl
  import mwa_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [AW-1:0] count,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          ld_en,
  output logic          ex_en,
  output logic          st_en,
  output logic          first,
  output op_e           op_q,
  output logic [AW-1:0] idx
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EXEC, ST_STORE} state_e;
  state_e        state;
  logic [AW-1:0] left;

  assign accept = start && (state == ST_IDLE) && op_valid(opcode);
  assign busy   = (state != ST_IDLE);
  assign ld_en  = (state == ST_LOAD);
  assign ex_en  = (state == ST_EXEC);
  assign st_en  = (state == ST_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      first <= 1'b0;
      idx   <= '0;
      left  <= '0;
      op_q  <= OP_ADD;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_q  <= op_e'(opcode);
          left  <= count;
          idx   <= (opcode == OP_SAR) ? count : '0;
          first <= 1'b1;
          state <= ST_LOAD;
        end
        ST_LOAD: state <= ST_EXEC;
        ST_EXEC: state <= ST_STORE;
        default: begin
          first <= 1'b0;
          if (left == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            left  <= left - 1'b1;
            idx   <= (op_q == OP_SAR) ? idx - 1'b1 : idx + 1'b1;
            state <= ST_LOAD;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mwa_top.sv
module mwa_top
  import mwa_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [AW-1:0] count,
  input  logic          t_map,
  input  logic [AW-1:0] t_base,
  input  logic          s_we,
  input  logic          t_we,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done
);
  localparam int S_RD = 3;
  localparam int T_RD = 2;

  logic          accept, ld_en, ex_en, st_en, first;
  op_e           op_q;
  logic [AW-1:0] idx, map_idx;
  logic [W-1:0]  a_q, b_q, alu_res;
  logic          cf, alu_cout;

  logic [S_RD*AW-1:0] s_raddr;
  logic [S_RD*W-1:0]  s_rdata;
  logic [T_RD*AW-1:0] t_raddr;
  logic [T_RD*W-1:0]  t_rdata;
  logic               s_wen;
  logic [AW-1:0]      s_waddr;
  logic [W-1:0]       s_wdata;

  mwa_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .count(count),
    .accept(accept), .busy(busy), .done(done), .ld_en(ld_en),
    .ex_en(ex_en), .st_en(st_en), .first(first), .op_q(op_q), .idx(idx)
  );

  assign map_idx = idx + t_base;
  assign s_raddr = {rd_addr, map_idx, idx};
  assign t_raddr = {rd_addr, idx};

  // controller store has the port while busy; host writes only when idle
  assign s_wen   = st_en || (s_we && !busy);
  assign s_waddr = st_en ? idx : wr_addr;
  assign s_wdata = st_en ? a_q : wr_data;

  mwa_spad #(.W(W), .DEPTH(DEPTH), .NRD(S_RD)) u_spad_s (
    .clk(clk), .we(s_wen), .waddr(s_waddr), .wdata(s_wdata),
    .raddr(s_raddr), .rdata(s_rdata)
  );

  mwa_spad #(.W(W), .DEPTH(DEPTH), .NRD(T_RD)) u_spad_t (
    .clk(clk), .we(t_we && !busy), .waddr(wr_addr), .wdata(wr_data),
    .raddr(t_raddr), .rdata(t_rdata)
  );

  mwa_alu #(.W(W)) u_alu (
    .op(op_q), .a(a_q), .b(b_q), .cin(cf), .first(first),
    .res(alu_res), .cout(alu_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      cf  <= 1'b0;
    end else begin
      if (accept) cf <= op_cin0(opcode);
      if (ld_en) begin
        a_q <= s_rdata[0 +: W];
        b_q <= t_map ? s_rdata[W +: W] : t_rdata[0 +: W];
      end
      if (ex_en) begin
        a_q <= alu_res;
        cf  <= alu_cout;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? t_rdata[W +: W] : s_rdata[2*W +: W];
  end
endmodule

// File: rtl/mwa_chk.sv
module mwa_chk
  import mwa_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(3*DEPTH + 1) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [2:0]    opcode,
  input logic [AW-1:0] count,
  input logic          busy,
  input logic          done
);
  logic          trk;
  logic [CW-1:0] cyc, lim;
  logic          acc_seen, bad_seen;

  assign acc_seen = start && !busy && op_valid(opcode);
  assign bad_seen = start && !busy && !op_valid(opcode);

  always_ff @(posedge clk) begin
    if (rst) begin
      trk <= 1'b0;
      cyc <= '0;
      lim <= '0;
    end else if (acc_seen) begin
      trk <= 1'b1;
      cyc <= '0;
      lim <= CW'(3 * (int'(count) + 1));
    end else if (trk) begin
      cyc <= cyc + 1'b1;
      if (done) trk <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done));

  assert_done_due_R8: assert property (@(posedge clk) disable iff (rst)
    (trk && cyc == lim) |-> done);

  assert_done_only_due_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (trk && cyc == lim));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_window_R8: assert property (@(posedge clk) disable iff (rst)
    (trk && cyc != lim) |-> busy);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !done) |=> busy);

  assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    bad_seen |=> !busy);
endmodule

bind mwa_top mwa_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode), .count(count),
  .busy(busy), .done(done)
);

// File: tb/tb_mwa_top.sv
module tb_mwa_top;
  localparam logic [2:0] C_ADD = 3'd0, C_SUB = 3'd1, C_NEG = 3'd2,
                         C_INC = 3'd3, C_SHL = 3'd4, C_SAR = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic [3:0]  count = '0;
  logic        t_map = 1'b0;
  logic [3:0]  t_base = '0;
  logic        s_we = 1'b0, t_we = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  logic [15:0] s_m [16];
  logic [15:0] t_m [16];

  always #2 clk = ~clk;

  mwa_top dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .count(count),
    .t_map(t_map), .t_base(t_base), .s_we(s_we), .t_we(t_we),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit to_t, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    s_we = !to_t; t_we = to_t; wr_addr = a; wr_data = d;
    @(negedge clk);
    s_we = 1'b0; t_we = 1'b0;
    if (to_t) t_m[a] = d; else s_m[a] = d;
  endtask

  task automatic rd(input bit from_t, input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_sel = from_t; rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic compare_s(input string req);
    logic [15:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(1'b0, 4'(i), d);
      check(d === s_m[i], req, 256'(d), 256'(s_m[i]));
    end
  endtask

  // returns at the negedge after the accepting edge
  task automatic kick(input logic [2:0] op, input int n, input bit mp,
                      input logic [3:0] base);
    @(negedge clk);
    start = 1'b1; opcode = op; count = 4'(n - 1); t_map = mp; t_base = base;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [255:0] model(input logic [2:0] op, input int n,
                                         input bit mp, input logic [3:0] base);
    logic [255:0] sv, tv, rv, msk;
    sv = '0; tv = '0;
    msk = (256'(1) << (16 * n)) - 256'(1);
    for (int i = 0; i < n; i++) begin
      sv[16*i +: 16] = s_m[i];
      tv[16*i +: 16] = mp ? s_m[(int'(base) + i) % 16] : t_m[i];
    end
    case (op)
      C_ADD:   rv = sv + tv;
      C_SUB:   rv = sv - tv;
      C_NEG:   rv = -sv;
      C_INC:   rv = sv + 256'(1);
      C_SHL:   rv = sv << 1;
      default: rv = (sv >> 1) | (256'(sv[16*n-1]) << (16*n - 1));
    endcase
    return rv & msk;
  endfunction

  task automatic commit(input logic [255:0] rv, input int n);
    for (int i = 0; i < n; i++) s_m[i] = rv[16*i +: 16];
  endtask

  task automatic run_op(input logic [2:0] op, input int n, input bit mp,
                        input logic [3:0] base, input string req);
    logic [255:0] rv;
    int cyc;
    rv = model(op, n, mp, base);
    kick(op, n, mp, base);
    wait_done(cyc);
    check(cyc == 3 * n, "R8 done timing", 256'(cyc), 256'(3 * n));
    commit(rv, n);
    compare_s(req);
  endtask

  task automatic fill(input logic [15:0] seed);
    for (int i = 0; i < 16; i++) begin
      wr(1'b0, 4'(i), seed ^ 16'(i * 16'h1111));
      wr(1'b1, 4'(i), ~seed + 16'(i * 16'h0707));
    end
  endtask

  task automatic t_reset();
    check(!busy && !done, "R1 reset idle", {busy, done}, 0);
  endtask

  task automatic t_add();
    wr(0, 0, 16'hFFFF); wr(0, 1, 16'hFFFF); wr(0, 2, 16'h7FFF);
    wr(1, 0, 16'h0001); wr(1, 1, 16'h0000); wr(1, 2, 16'h0000);
    run_op(C_ADD, 3, 0, 0, "R2 add carry chain");
  endtask

  task automatic t_sub();
    wr(0, 0, 16'h0000); wr(0, 1, 16'h0000);
    wr(1, 0, 16'h0001); wr(1, 1, 16'h0000);
    run_op(C_SUB, 2, 0, 0, "R3 sub borrow");
    wr(0, 0, 16'h1234); wr(0, 1, 16'h8000);
    wr(1, 0, 16'h5678); wr(1, 1, 16'h0001);
    run_op(C_SUB, 2, 0, 0, "R3 sub mixed");
  endtask

  task automatic t_neg();
    wr(0, 0, 16'h0001); wr(0, 1, 16'h0000);
    run_op(C_NEG, 2, 0, 0, "R4 negate one");
    wr(0, 0, 16'h8000);
    run_op(C_NEG, 1, 0, 0, "R4 negate most negative");
  endtask

  task automatic t_inc();
    for (int i = 0; i < 4; i++) wr(0, 4'(i), 16'hFFFF);
    run_op(C_INC, 4, 0, 0, "R5 increment wrap");
    wr(0, 0, 16'h00FF);
    run_op(C_INC, 2, 0, 0, "R5 increment plain");
  endtask

  task automatic t_shl();
    wr(0, 0, 16'h8001); wr(0, 1, 16'h8000); wr(0, 2, 16'h4000);
    run_op(C_SHL, 3, 0, 0, "R6 shift left");
  endtask

  task automatic t_sar();
    wr(0, 0, 16'h0002); wr(0, 1, 16'h0001); wr(0, 2, 16'h8001);
    run_op(C_SAR, 3, 0, 0, "R7 sar negative");
    wr(0, 0, 16'hFFFF); wr(0, 1, 16'h7FFF);
    run_op(C_SAR, 2, 0, 0, "R7 sar positive");
  endtask

  task automatic t_busy_start();
    logic [255:0] rv;
    int cyc;
    wr(0, 0, 16'hF000); wr(0, 1, 16'h0001);
    wr(1, 0, 16'h1000); wr(1, 1, 16'h0002);
    rv = model(C_ADD, 2, 0, 0);
    kick(C_ADD, 2, 0, 0);
    start = 1'b1; opcode = C_NEG;
    @(negedge clk);
    cyc = 1;
    start = 1'b0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 6, "R9 late start no delay", 256'(cyc), 256'(6));
    commit(rv, 2);
    compare_s("R9 late start no effect");
  endtask

  task automatic t_reserved();
    bit seen;
    seen = 0;
    @(negedge clk);
    start = 1'b1; opcode = 3'd6; count = 4'd3;
    @(negedge clk);
    opcode = 3'd7;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy || done) seen = 1;
    end
    check(!seen, "R10 reserved opcode idle", 256'(seen), 0);
    compare_s("R10 reserved opcode S unchanged");
  endtask

  task automatic t_alias();
    wr(0, 0, 16'hFFFF); wr(0, 1, 16'h0010);
    wr(0, 4, 16'h0002); wr(0, 5, 16'h0100);
    wr(1, 0, 16'h5555); wr(1, 1, 16'h5555);
    run_op(C_ADD, 2, 1, 4'd4, "R11 mapped operand");
  endtask

  task automatic t_single();
    wr(0, 0, 16'hFFFF); wr(0, 1, 16'h0042);
    wr(1, 0, 16'h0003);
    run_op(C_ADD, 1, 0, 0, "R12 single word");
  endtask

  task automatic t_write_busy();
    logic [255:0] rv;
    logic [15:0] d;
    int cyc;
    rv = model(C_INC, 4, 0, 0);
    kick(C_INC, 4, 0, 0);
    s_we = 1'b1; t_we = 1'b1; wr_addr = 4'd10; wr_data = 16'hDEAD;
    @(negedge clk);
    s_we = 1'b0; t_we = 1'b0;
    wait_done(cyc);
    commit(rv, 4);
    compare_s("R13 S write while busy");
    rd(1'b1, 4'd10, d);
    check(d === t_m[10], "R13 T write while busy", 256'(d), 256'(t_m[10]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    fill(16'hA5C3);
    t_add();
    t_sub();
    t_neg();
    t_inc();
    t_shl();
    t_sar();
    t_busy_start();
    t_reserved();
    t_alias();
    t_single();
    t_write_busy();
    fill(16'h3C96);
    run_op(C_ADD, 16, 0, 0, "R2 add sixteen words");
    run_op(C_SAR, 16, 0, 0, "R7 sar sixteen words");
    report();
  end
endmodule